// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic unit of a small single-cycle RISC core. It also holds the core's eight-bit status register. The caller supplies a destination-register value and a second operand. The second operand is either a source-register value or an 8-bit immediate, selected by `useImm`. The caller also supplies an operation code, a bit index and a valid strobe. The result and the write-back enable are combinational, so a register file can capture them at the same edge that updates the flags.

The status register updates on the rising clock edge whenever `opValid` is high. Each operation changes the flags according to its own rule:

- Rotates pass through the carry.
- Subtract-with-carry and compare-with-carry chain the zero flag across bytes.
- The transfer flag T moves single bits between an operand and the status register.

Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. The flag set and clear operations, and the transfer-flag operations, depend on these positions.

Top module: `alu8_status`

## Requirements
- R1: While `rstN` is low, `flags` is 0x00; with `opValid` low, `writeEn` is low.
- R2: Add (code 0) and add-with-carry (code 1) give A+B(+C). H is the carry out of bit 3, C is the carry out of bit 7, V is signed overflow, N is bit 7, Z is set for a zero result, S=N^V. The result is written back.
- R3: Subtract (code 2) and subtract-with-carry (code 3) give A−B(−C). H and C are borrows out of bit 3 and bit 7, and V is signed overflow. For code 3 the new Z is (result==0) AND old Z.
- R4: Compare (code 21) and compare-with-carry (code 22) set flags exactly as codes 2 and 3, with the immediate usable as B. `writeEn` stays low.
- R5: AND (4), OR (5) and XOR (6) clear V, set N, Z and S=N, and keep C and H.
- R6: One's complement (7) always sets C and clears V. Negate (8) gives 0−A, sets C when the result is nonzero, sets V when the result is 0x80, and sets H = result bit 3 OR A bit 3.
- R7: Increment (9) and decrement (10) set V only for 0x7F→0x80 and 0x80→0x7F respectively, and keep C and H.
- R8: Shift left (11), logical shift right (12) and arithmetic shift right (15) load C with the bit shifted out, set V=N^C, and keep H. Code 12 fills 0 into bit 7. Code 15 keeps bit 7.
- R9: Rotate left (13) puts old C into bit 0 and bit 7 into C. Rotate right (14) puts old C into bit 7 and bit 0 into C. V=N^C.
- R10: Nibble swap (16) exchanges bits 7..4 with bits 3..0 and leaves all flags unchanged.
- R11: Bit store (17) copies A[`bitIdx`] into T (bit 6) with no write-back. Bit load (18) returns A with bit `bitIdx` replaced by T.
- R12: Flag set (19) and flag clear (20) change only status bit `bitIdx` and write nothing back.
- R13: With `opValid` low, or with a code from 23 to 31, `writeEn` is low and `flags` keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation is executed this cycle |
| opCode | input | 5 | Operation code (see requirements) |
| rdVal | input | 8 | Destination register operand A |
| rrVal | input | 8 | Source register operand |
| immVal | input | 8 | Immediate operand |
| useImm | input | 1 | Selects immVal as operand B |
| bitIdx | input | 3 | Bit or flag index |
| result | output | 8 | Combinational result |
| writeEn | output | 1 | Result is to be written back |
| flags | output | 8 | Registered status flags |

## Verification
On every cycle, the checker properties cover the following:

- Compares never write back.
- The chained zero flag is never raised by codes 3 and 22.
- Complement sets carry, and negate's carry tracks a nonzero operand.
- Logic operations clear V.
- Swap and idle cycles leave the flags untouched.
- Flag set raises the chosen bit.
- The sign flag after an add equals N XOR V.

Exact result values, the half-carry and overflow of every arithmetic form, and the bit transfers through T are shown only by the bench. It compares each operation against an independent reference, both on random operands and on directed edges such as 0x7F+1, 0x80 negation and multi-byte compare chains.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int FLAG_W = 8;
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;
  localparam int FLG_T = 6;
  localparam int FLG_I = 7;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0, OP_ADC = 5'd1, OP_SUB = 5'd2, OP_SBC = 5'd3,
    OP_AND = 5'd4, OP_OR = 5'd5, OP_XOR = 5'd6, OP_COM = 5'd7,
    OP_NEG = 5'd8, OP_INC = 5'd9, OP_DEC = 5'd10, OP_LSL = 5'd11,
    OP_LSR = 5'd12, OP_ROL = 5'd13, OP_ROR = 5'd14, OP_ASR = 5'd15,
    OP_SWAP = 5'd16, OP_BST = 5'd17, OP_BLD = 5'd18, OP_BSET = 5'd19,
    OP_BCLR = 5'd20, OP_CP = 5'd21, OP_CPC = 5'd22
  } aluOp_t;

  typedef enum logic [3:0] {
    K_NONE, K_ARITH, K_LOGIC, K_COM, K_NEG, K_INCDEC,
    K_SHIFT, K_SWAP, K_BST, K_BLD, K_FLAG
  } unitKind_t;

  typedef struct packed {
    logic       writeBack;
    logic       isSub;
    logic       useCarry;
    logic       chainZ;
    logic       setFlag;
    logic [2:0] subSel;
    unitKind_t  kind;
  } aluStrobe_t;
endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [4:0] opCode,
  output aluStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    strobe.kind = K_NONE;
    case (aluOp_t'(opCode))
      OP_ADD:  begin strobe.kind = K_ARITH; strobe.writeBack = 1'b1; end
      OP_ADC:  begin strobe.kind = K_ARITH; strobe.writeBack = 1'b1; strobe.useCarry = 1'b1; end
      OP_SUB:  begin strobe.kind = K_ARITH; strobe.writeBack = 1'b1; strobe.isSub = 1'b1; end
      OP_SBC:  begin
        strobe.kind = K_ARITH; strobe.writeBack = 1'b1; strobe.isSub = 1'b1;
        strobe.useCarry = 1'b1; strobe.chainZ = 1'b1;
      end
      OP_CP:   begin strobe.kind = K_ARITH; strobe.isSub = 1'b1; end
      OP_CPC:  begin
        strobe.kind = K_ARITH; strobe.isSub = 1'b1;
        strobe.useCarry = 1'b1; strobe.chainZ = 1'b1;
      end
      OP_AND:  begin strobe.kind = K_LOGIC; strobe.writeBack = 1'b1; strobe.subSel = 3'd0; end
      OP_OR:   begin strobe.kind = K_LOGIC; strobe.writeBack = 1'b1; strobe.subSel = 3'd1; end
      OP_XOR:  begin strobe.kind = K_LOGIC; strobe.writeBack = 1'b1; strobe.subSel = 3'd2; end
      OP_COM:  begin strobe.kind = K_COM; strobe.writeBack = 1'b1; end
      OP_NEG:  begin strobe.kind = K_NEG; strobe.writeBack = 1'b1; end
      OP_INC:  begin strobe.kind = K_INCDEC; strobe.writeBack = 1'b1; end
      OP_DEC:  begin strobe.kind = K_INCDEC; strobe.writeBack = 1'b1; strobe.isSub = 1'b1; end
      OP_LSL:  begin strobe.kind = K_SHIFT; strobe.writeBack = 1'b1; strobe.subSel = 3'd0; end
      OP_LSR:  begin strobe.kind = K_SHIFT; strobe.writeBack = 1'b1; strobe.subSel = 3'd1; end
      OP_ROL:  begin strobe.kind = K_SHIFT; strobe.writeBack = 1'b1; strobe.subSel = 3'd2; end
      OP_ROR:  begin strobe.kind = K_SHIFT; strobe.writeBack = 1'b1; strobe.subSel = 3'd3; end
      OP_ASR:  begin strobe.kind = K_SHIFT; strobe.writeBack = 1'b1; strobe.subSel = 3'd4; end
      OP_SWAP: begin strobe.kind = K_SWAP; strobe.writeBack = 1'b1; end
      OP_BST:  strobe.kind = K_BST;
      OP_BLD:  begin strobe.kind = K_BLD; strobe.writeBack = 1'b1; end
      OP_BSET: begin strobe.kind = K_FLAG; strobe.setFlag = 1'b1; end
      OP_BCLR: strobe.kind = K_FLAG;
      default: strobe.kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluStrobe_t                  strobe,
  input  logic [DATA_W-1:0]           opA,
  input  logic [DATA_W-1:0]           opB,
  input  logic [FLAG_W-1:0]           flagsIn,
  input  logic [$clog2(DATA_W)-1:0]   bitIdx,
  output logic [DATA_W-1:0]           resOut,
  output logic [FLAG_W-1:0]           flagsNext
);
  localparam int MSB  = DATA_W - 1;
  localparam int HALF = DATA_W / 2;
  localparam int HB   = HALF - 1;
  localparam logic [DATA_W-1:0] ONE_V = DATA_W'(1);
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] addB, bx;
  logic              cinEff;
  logic [DATA_W:0]   sumW;
  logic [HALF:0]     halfW;
  logic [DATA_W-1:0] sumR;
  logic              updNzs;

  // shared adder: subtraction as A + ~B + ~borrow
  always_comb begin
    addB   = (strobe.kind == K_INCDEC) ? ONE_V : opB;
    bx     = strobe.isSub ? ~addB : addB;
    cinEff = (strobe.useCarry & flagsIn[FLG_C]) ^ strobe.isSub;
    sumW   = {1'b0, opA} + {1'b0, bx} + {{DATA_W{1'b0}}, cinEff};
    halfW  = {1'b0, opA[HB:0]} + {1'b0, bx[HB:0]} + {{HALF{1'b0}}, cinEff};
    sumR   = sumW[MSB:0];
  end

  always_comb begin
    resOut    = opA;
    flagsNext = flagsIn;
    updNzs    = 1'b0;
    case (strobe.kind)
      K_ARITH: begin
        resOut           = sumR;
        flagsNext[FLG_C] = sumW[DATA_W] ^ strobe.isSub;
        flagsNext[FLG_H] = halfW[HALF] ^ strobe.isSub;
        flagsNext[FLG_V] = (opA[MSB] == bx[MSB]) && (sumR[MSB] != opA[MSB]);
        updNzs           = 1'b1;
      end
      K_INCDEC: begin
        resOut           = sumR;
        flagsNext[FLG_V] = (opA[MSB] == bx[MSB]) && (sumR[MSB] != opA[MSB]);
        updNzs           = 1'b1;
      end
      K_LOGIC: begin
        case (strobe.subSel)
          3'd0:    resOut = opA & opB;
          3'd1:    resOut = opA | opB;
          default: resOut = opA ^ opB;
        endcase
        flagsNext[FLG_V] = 1'b0;
        updNzs           = 1'b1;
      end
      K_COM: begin
        resOut           = ~opA;
        flagsNext[FLG_C] = 1'b1;
        flagsNext[FLG_V] = 1'b0;
        updNzs           = 1'b1;
      end
      K_NEG: begin
        resOut           = -opA;
        flagsNext[FLG_C] = |opA;
        flagsNext[FLG_V] = (opA == MIN_V);
        flagsNext[FLG_H] = resOut[HB] | opA[HB];
        updNzs           = 1'b1;
      end
      K_SHIFT: begin
        case (strobe.subSel)
          3'd0: begin resOut = {opA[MSB-1:0], 1'b0};             flagsNext[FLG_C] = opA[MSB]; end
          3'd1: begin resOut = {1'b0, opA[MSB:1]};               flagsNext[FLG_C] = opA[0];   end
          3'd2: begin resOut = {opA[MSB-1:0], flagsIn[FLG_C]};   flagsNext[FLG_C] = opA[MSB]; end
          3'd3: begin resOut = {flagsIn[FLG_C], opA[MSB:1]};     flagsNext[FLG_C] = opA[0];   end
          default: begin resOut = {opA[MSB], opA[MSB:1]};        flagsNext[FLG_C] = opA[0];   end
        endcase
        flagsNext[FLG_V] = resOut[MSB] ^ flagsNext[FLG_C];
        updNzs           = 1'b1;
      end
      K_SWAP:  resOut = {opA[HB:0], opA[MSB:HALF]};
      K_BST:   flagsNext[FLG_T] = opA[bitIdx];
      K_BLD:   resOut[bitIdx] = flagsIn[FLG_T];
      K_FLAG:  flagsNext[bitIdx] = strobe.setFlag;
      default: ;
    endcase
    if (updNzs) begin
      flagsNext[FLG_N] = resOut[MSB];
      flagsNext[FLG_Z] = (resOut == '0) & (~strobe.chainZ | flagsIn[FLG_Z]);
      flagsNext[FLG_S] = flagsNext[FLG_N] ^ flagsNext[FLG_V];
    end
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        opValid,
  input  logic [4:0]                  opCode,
  input  logic [DATA_W-1:0]           rdVal,
  input  logic [DATA_W-1:0]           rrVal,
  input  logic [DATA_W-1:0]           immVal,
  input  logic                        useImm,
  input  logic [$clog2(DATA_W)-1:0]   bitIdx,
  output logic [DATA_W-1:0]           result,
  output logic                        writeEn,
  output logic [FLAG_W-1:0]           flags
);
  aluStrobe_t        strobe;
  logic [DATA_W-1:0] operandB;
  logic [FLAG_W-1:0] flagsNext;

  assign operandB = useImm ? immVal : rrVal;

  alu8_ctrl i_ctrl (
    .opCode (opCode),
    .strobe (strobe)
  );

  alu8_datapath #(.DATA_W(DATA_W)) i_dp (
    .strobe    (strobe),
    .opA       (rdVal),
    .opB       (operandB),
    .flagsIn   (flags),
    .bitIdx    (bitIdx),
    .resOut    (result),
    .flagsNext (flagsNext)
  );

  assign writeEn = opValid & strobe.writeBack;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        flags <= '0;
    else if (opValid) flags <= flagsNext;
  end
endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      opValid,
  input logic [4:0]                opCode,
  input logic [DATA_W-1:0]         rdVal,
  input logic [$clog2(DATA_W)-1:0] bitIdx,
  input logic                      writeEn,
  input logic [FLAG_W-1:0]         flags
);
  // R4
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 5'd21 || opCode == 5'd22) |-> !writeEn);

  // R3
  chain_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 5'd3 || opCode == 5'd22) && !flags[FLG_Z]) |=> !flags[FLG_Z]);

  // R6
  com_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 5'd7) |=> flags[FLG_C]);

  // R6
  neg_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 5'd8) |=> (flags[FLG_C] == ($past(rdVal) != '0)));

  // R5
  logic_clr_v_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode >= 5'd4 && opCode <= 5'd6) |=> !flags[FLG_V]);

  // R2
  add_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode <= 5'd1) |=> (flags[FLG_S] == (flags[FLG_N] ^ flags[FLG_V])));

  // R10
  swap_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 5'd16) |=> $stable(flags));

  // R12
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 5'd19) |=> flags[$past(bitIdx)]);

  // R13
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(flags));

  // R13
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> !writeEn);
endmodule

bind alu8_status alu8_status_chk #(.DATA_W(DATA_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .opValid (opValid),
  .opCode  (opCode),
  .rdVal   (rdVal),
  .bitIdx  (bitIdx),
  .writeEn (writeEn),
  .flags   (flags)
);

// File: tb/test_alu8_status.sv
module test_alu8_status;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [4:0] opCode = '0;
  logic [7:0] rdVal = '0, rrVal = '0, immVal = '0;
  logic       useImm = 1'b0;
  logic [2:0] bitIdx = '0;
  logic [7:0] result;
  logic       writeEn;
  logic [7:0] flags;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] expFlags = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  alu8_status i_alu8_status (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .rdVal(rdVal), .rrVal(rrVal), .immVal(immVal), .useImm(useImm),
    .bitIdx(bitIdx), .result(result), .writeEn(writeEn), .flags(flags)
  );

  function automatic string reqOf(input logic [4:0] op, input logic valid);
    if (!valid) return "R13";
    case (op)
      0, 1:       return "R2";
      2, 3:       return "R3";
      21, 22:     return "R4";
      4, 5, 6:    return "R5";
      7, 8:       return "R6";
      9, 10:      return "R7";
      11, 12, 15: return "R8";
      13, 14:     return "R9";
      16:         return "R10";
      17, 18:     return "R11";
      19, 20:     return "R12";
      default:    return "R13";
    endcase
  endfunction

  // reference: returns {writeBack, result, nextFlags}
  function automatic logic [16:0] refModel(input logic [4:0] op, input logic [7:0] a,
                                           input logic [7:0] b, input logic [7:0] f,
                                           input logic [2:0] idx);
    logic [7:0] r = a;
    logic [7:0] nf = f;
    logic wr = 1'b0;
    logic nzs = 1'b0;
    logic cin;
    case (op)
      0, 1: begin
        cin = (op == 1) & f[0];
        r = a + b + {7'd0, cin};
        nf[5] = (a[3] & b[3]) | (b[3] & ~r[3]) | (~r[3] & a[3]);
        nf[3] = (a[7] & b[7] & ~r[7]) | (~a[7] & ~b[7] & r[7]);
        nf[0] = (a[7] & b[7]) | (b[7] & ~r[7]) | (~r[7] & a[7]);
        nzs = 1'b1; wr = 1'b1;
      end
      2, 3, 21, 22: begin
        cin = (op == 3 || op == 22) & f[0];
        r = a - b - {7'd0, cin};
        nf[5] = (~a[3] & b[3]) | (b[3] & r[3]) | (r[3] & ~a[3]);
        nf[3] = (a[7] & ~b[7] & ~r[7]) | (~a[7] & b[7] & r[7]);
        nf[0] = (~a[7] & b[7]) | (b[7] & r[7]) | (r[7] & ~a[7]);
        nzs = 1'b1; wr = (op == 2 || op == 3);
      end
      4: begin r = a & b; nf[3] = 1'b0; nzs = 1'b1; wr = 1'b1; end
      5: begin r = a | b; nf[3] = 1'b0; nzs = 1'b1; wr = 1'b1; end
      6: begin r = a ^ b; nf[3] = 1'b0; nzs = 1'b1; wr = 1'b1; end
      7: begin r = ~a; nf[0] = 1'b1; nf[3] = 1'b0; nzs = 1'b1; wr = 1'b1; end
      8: begin
        r = 8'h00 - a; nf[5] = r[3] | a[3]; nf[3] = (r == 8'h80);
        nf[0] = (r != 8'h00); nzs = 1'b1; wr = 1'b1;
      end
      9:  begin r = a + 8'd1; nf[3] = (a == 8'h7F); nzs = 1'b1; wr = 1'b1; end
      10: begin r = a - 8'd1; nf[3] = (a == 8'h80); nzs = 1'b1; wr = 1'b1; end
      11: begin r = {a[6:0], 1'b0}; nf[0] = a[7]; nf[3] = a[6] ^ a[7]; nzs = 1'b1; wr = 1'b1; end
      12: begin r = {1'b0, a[7:1]}; nf[0] = a[0]; nf[3] = a[0]; nzs = 1'b1; wr = 1'b1; end
      13: begin r = {a[6:0], f[0]}; nf[0] = a[7]; nf[3] = a[6] ^ a[7]; nzs = 1'b1; wr = 1'b1; end
      14: begin r = {f[0], a[7:1]}; nf[0] = a[0]; nf[3] = f[0] ^ a[0]; nzs = 1'b1; wr = 1'b1; end
      15: begin r = {a[7], a[7:1]}; nf[0] = a[0]; nf[3] = a[7] ^ a[0]; nzs = 1'b1; wr = 1'b1; end
      16: begin r = {a[3:0], a[7:4]}; wr = 1'b1; end
      17: nf[6] = a[idx];
      18: begin r[idx] = f[6]; wr = 1'b1; end
      19: nf[idx] = 1'b1;
      20: nf[idx] = 1'b0;
      default: ;
    endcase
    if (nzs) begin
      nf[2] = r[7];
      nf[1] = (op == 3 || op == 22) ? ((r == 8'h00) & f[1]) : (r == 8'h00);
      nf[4] = nf[2] ^ nf[3];
    end
    return {wr, r, nf};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doOp(input logic valid, input logic [4:0] op, input logic [7:0] a,
                      input logic [7:0] b, input logic [7:0] imm, input logic ui,
                      input logic [2:0] idx);
    logic [16:0] m;
    logic expWr;
    string req;
    @(negedge clk);
    opValid = valid; opCode = op; rdVal = a; rrVal = b; immVal = imm;
    useImm = ui; bitIdx = idx;
    req = reqOf(op, valid);
    m = refModel(op, a, ui ? imm : b, expFlags, idx);
    expWr = valid & m[16];
    #1;
    check(req, "writeEn", {7'd0, writeEn}, {7'd0, expWr});
    if (expWr) check(req, "result", result, m[15:8]);
    @(posedge clk);
    #1;
    if (valid) expFlags = m[7:0];
    check(req, "flags", flags, expFlags);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5A17);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "flags in reset", flags, 8'h00);
    check("R1", "writeEn in reset", {7'd0, writeEn}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    // R2 overflow and carry edges
    doOp(1, 5'd0, 8'h7F, 8'h01, 8'h00, 0, 0);
    doOp(1, 5'd0, 8'hFF, 8'h00, 8'h01, 1, 0);
    doOp(1, 5'd1, 8'h0F, 8'h00, 8'h00, 0, 0);
    // R3 / R4 multi-byte compare chain: 0x0100 vs 0x0100
    doOp(1, 5'd21, 8'h00, 8'h00, 8'h00, 0, 0);
    doOp(1, 5'd22, 8'h01, 8'h01, 8'h00, 0, 0);
    doOp(1, 5'd21, 8'h00, 8'h01, 8'h00, 0, 0);
    doOp(1, 5'd22, 8'h01, 8'h00, 8'h00, 0, 0);
    doOp(1, 5'd3, 8'h00, 8'h00, 8'h00, 0, 0);
    doOp(1, 5'd21, 8'h10, 8'h00, 8'h10, 1, 0);
    // R6
    doOp(1, 5'd8, 8'h80, 8'h00, 8'h00, 0, 0);
    doOp(1, 5'd8, 8'h00, 8'h00, 8'h00, 0, 0);
    doOp(1, 5'd7, 8'h5A, 8'h00, 8'h00, 0, 0);
    // R7
    doOp(1, 5'd9, 8'h7F, 8'h00, 8'h00, 0, 0);
    doOp(1, 5'd10, 8'h80, 8'h00, 8'h00, 0, 0);
    // R8 / R9
    doOp(1, 5'd15, 8'h81, 8'h00, 8'h00, 0, 0);
    doOp(1, 5'd13, 8'h80, 8'h00, 8'h00, 0, 0);
    doOp(1, 5'd14, 8'h01, 8'h00, 8'h00, 0, 0);
    doOp(1, 5'd12, 8'hFF, 8'h00, 8'h00, 0, 0);
    // R10, R11, R12
    doOp(1, 5'd16, 8'hA5, 8'h00, 8'h00, 0, 0);
    doOp(1, 5'd17, 8'h08, 8'h00, 8'h00, 0, 3);
    doOp(1, 5'd18, 8'h00, 8'h00, 8'h00, 0, 7);
    doOp(1, 5'd19, 8'h00, 8'h00, 8'h00, 0, 7);
    doOp(1, 5'd20, 8'h00, 8'h00, 8'h00, 0, 6);
    // R13 idle and undefined codes
    doOp(0, 5'd19, 8'h00, 8'h00, 8'h00, 0, 2);
    doOp(1, 5'd27, 8'h33, 8'h44, 8'h00, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [4:0] op;
      logic valid;
      op = ($urandom_range(0, 9) == 0) ? 5'($urandom_range(23, 31)) : 5'($urandom_range(0, 22));
      valid = ($urandom_range(0, 15) != 0);
      doOp(valid, op, 8'($urandom), 8'($urandom), 8'($urandom),
           1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule